// File: doc/BRIEF.md
# Temporal Dither Color Depth Reducer

This block narrows a 24-bit RGB pixel stream (8 bits per component) to an 18-bit stream (6 bits per component) for a panel datapath that only carries six bits per color. Two mode pins choose the reduction at run time. The first choice is plain truncation. The second is frame-sequenced dithering, in which the two dropped bits decide whether a component is rounded up. The third choice is a pass-through for sources that already deliver 18-bit color.

The dither threshold comes from a 2x2 ordered pattern. Its index is the pixel's column parity and line parity, combined by XOR with a 2-bit frame counter. As a result, every screen position sees all four thresholds over four consecutive frames. The time average of the 6-bit output therefore equals the 8-bit input divided by four. Frame-start and line-start pulses travel with the first pixel of a frame or line. The result leaves through one register stage.

Top module: `depth_reducer`

## Requirements
- R1: While reset is high, and on the first cycle after it, `out_valid` is 0 and `pix_out` is 0. The frame count, line parity and column parity all start at 0.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, in every mode.
- R3: With `mode` = 2'b00 (truncate), each output component is bits [7:2] of its input component. Red is `pix_in[23:16]` → `pix_out[17:12]`, green is `pix_in[15:8]` → `pix_out[11:6]`, and blue is `pix_in[7:0]` → `pix_out[5:0]`.
- R4: With `mode[1]` = 1 (2'b10 or 2'b11), `pix_out` equals `pix_in[17:0]`, unchanged, and `pix_in[23:18]` is ignored.
- R5: With `mode` = 2'b01 (dither), a component's output is its bits [7:2], plus 1 when bits [1:0] are greater than a threshold T. T = P[{line,col} XOR frame], where P[0]=0, P[1]=2, P[2]=3 and P[3]=1, `line` is index bit 1 and `col` is index bit 0.
- R6: A dither increment on a component whose bits [7:2] are 63 leaves the output at 63. It never wraps to 0.
- R7: The frame count increases by 1 on each `frame_start` and wraps to 0 after 3. The pixel arriving with `frame_start` already uses the new count. The dither pattern therefore repeats every four frames.
- R8: Line parity toggles on each `line_start` and is cleared to 0 by `frame_start`, which takes priority. The pixel arriving with the pulse uses the new parity.
- R9: Column parity is 0 for the pixel arriving with `line_start` or `frame_start`. It toggles after each valid pixel and does not change on cycles with `in_valid` low.
- R10: When `in_valid` is low, `pix_out` keeps its previous value.
- R11: In dither mode, for a component below 252, the four outputs at one screen position over four consecutive frames add up to exactly the 8-bit input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| frame_start | input | 1 | Marks the first pixel of a frame |
| line_start | input | 1 | Marks the first pixel of a line |
| mode | input | 2 | 00 truncate, 01 dither, 1x pass-through |
| pix_in | input | 24 | Input pixel {R,G,B}; low 18 bits carry pass-through data |
| out_valid | output | 1 | Output pixel qualifier, one cycle after input |
| pix_out | output | 18 | Reduced pixel {R,G,B}, 6 bits each |

## Verification
The hardest situation to reach is one where the threshold index depends on all three position states at once. A column parity has to be frozen across invalid cycles. A line parity has to be left odd when a new frame starts. The frame count has to have wrapped. The bench keeps its own position model, written from R7 to R9. It drives frames with odd line counts and with gaps inside lines, and runs more than four frames. It then checks every dithered pixel against that model and checks the four-frame sums from R11 directly.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic [1:0] {
    MODE_TRUNC    = 2'b00,
    MODE_DITHER   = 2'b01,
    MODE_PASS     = 2'b10,
    MODE_PASS_ALT = 2'b11
  } reduce_mode_e;

  // 2x2 ordered threshold pattern, index = {line_parity, column_parity}
  function automatic logic [1:0] pattern2x2(input logic [1:0] idx);
    logic [1:0] thr;
    case (idx)
      2'd0:    thr = 2'd0;
      2'd1:    thr = 2'd2;
      2'd2:    thr = 2'd3;
      default: thr = 2'd1;
    endcase
    return thr;
  endfunction

endpackage

// File: rtl/cdr_position.sv
module cdr_position #(
  parameter int FRAME_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               frame_start,
  input  logic               line_start,
  output logic [FRAME_W-1:0] frame_idx,
  output logic               line_par,
  output logic               col_par
);

  logic [FRAME_W-1:0] frame_q;
  logic               line_q;
  logic               col_q;

  // Position seen by the pixel present this cycle
  always_comb begin
    frame_idx = frame_q;
    line_par  = line_q;
    col_par   = col_q;
    if (frame_start) begin
      frame_idx = frame_q + 1'b1;
      line_par  = 1'b0;
      col_par   = 1'b0;
    end else if (line_start) begin
      line_par  = ~line_q;
      col_par   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
      line_q  <= 1'b0;
      col_q   <= 1'b0;
    end else begin
      frame_q <= frame_idx;
      line_q  <= line_par;
      col_q   <= in_valid ? ~col_par : col_par;
    end
  end

endmodule

// File: rtl/cdr_threshold.sv
module cdr_threshold #(
  parameter int FRAME_W = 2,
  parameter int DROP_W  = 2
) (
  input  logic [FRAME_W-1:0] frame_idx,
  input  logic               line_par,
  input  logic               col_par,
  output logic [DROP_W-1:0]  thr
);
  import cdr_pkg::*;

  localparam int SCALE = DROP_W - 2;

  logic [1:0] idx;
  logic [1:0] base;

  always_comb begin
    idx  = {line_par, col_par} ^ frame_idx[1:0];
    base = pattern2x2(idx);
  end

  generate
    if (SCALE == 0) begin : g_exact
      assign thr = base;
    end else begin : g_scaled
      assign thr = {base, {SCALE{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/cdr_component.sv
module cdr_component #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 6
) (
  input  logic [1:0]            mode,
  input  logic [IN_W-1:0]       comp_in,
  input  logic [OUT_W-1:0]      pass_in,
  input  logic [IN_W-OUT_W-1:0] thr,
  output logic [OUT_W-1:0]      comp_out
);
  import cdr_pkg::*;

  localparam int DROP_W = IN_W - OUT_W;

  logic [OUT_W-1:0]  top;
  logic [DROP_W-1:0] low;
  logic              bump;

  always_comb begin
    top  = comp_in[IN_W-1:DROP_W];
    low  = comp_in[DROP_W-1:0];
    bump = (low > thr) && (top != {OUT_W{1'b1}});
    case (reduce_mode_e'(mode))
      MODE_TRUNC:  comp_out = top;
      MODE_DITHER: comp_out = top + {{(OUT_W-1){1'b0}}, bump};
      default:     comp_out = pass_in;
    endcase
  end

endmodule

// File: rtl/depth_reducer.sv
module depth_reducer #(
  parameter int IN_W    = 8,
  parameter int OUT_W   = 6,
  parameter int NUM_CH  = 3,
  parameter int FRAME_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    frame_start,
  input  logic                    line_start,
  input  logic [1:0]              mode,
  input  logic [NUM_CH*IN_W-1:0]  pix_in,
  output logic                    out_valid,
  output logic [NUM_CH*OUT_W-1:0] pix_out
);

  localparam int DROP_W = IN_W - OUT_W;

  logic [FRAME_W-1:0]      frame_idx;
  logic                    line_par;
  logic                    col_par;
  logic [DROP_W-1:0]       thr;
  logic [NUM_CH*OUT_W-1:0] reduced;

  cdr_position #(.FRAME_W(FRAME_W)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .frame_start (frame_start),
    .line_start  (line_start),
    .frame_idx   (frame_idx),
    .line_par    (line_par),
    .col_par     (col_par)
  );

  cdr_threshold #(.FRAME_W(FRAME_W), .DROP_W(DROP_W)) u_thr (
    .frame_idx (frame_idx),
    .line_par  (line_par),
    .col_par   (col_par),
    .thr       (thr)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      cdr_component #(.IN_W(IN_W), .OUT_W(OUT_W)) u_comp (
        .mode     (mode),
        .comp_in  (pix_in[ch*IN_W +: IN_W]),
        .pass_in  (pix_in[ch*OUT_W +: OUT_W]),
        .thr      (thr),
        .comp_out (reduced[ch*OUT_W +: OUT_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) pix_out <= reduced;
    end
  end

endmodule

// File: rtl/cdr_checker.sv
module cdr_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [1:0]  mode,
  input logic [23:0] pix_in,
  input logic        out_valid,
  input logic [17:0] pix_out
);

  // R2: one-cycle qualifier latency
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10: hold while idle
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pix_out));

  // R3: truncation keeps upper bits
  p_trunc_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00) |=>
      pix_out == {$past(pix_in[23:18]), $past(pix_in[15:10]), $past(pix_in[7:2])});

  // R4: pass-through of low 18 bits
  p_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode[1]) |=> pix_out == $past(pix_in[17:0]));

  // R5: zero dropped bits never round up
  p_zero_low_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01 && pix_in[17:16] == 2'b00) |=>
      pix_out[17:12] == $past(pix_in[23:18]));

  // R5: dithered red stays within one step above truncation
  p_dither_span_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01) |=>
      (pix_out[17:12] == $past(pix_in[23:18])) ||
      (pix_out[17:12] == $past(pix_in[23:18]) + 6'd1));

  // R6: saturation at full scale
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b01 && pix_in[7:2] == 6'h3f) |=>
      pix_out[5:0] == 6'h3f);

endmodule

bind depth_reducer cdr_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .pix_in    (pix_in),
  .out_valid (out_valid),
  .pix_out   (pix_out)
);

// File: tb/sim_depth_reducer.sv
module sim_depth_reducer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        frame_start;
  logic        line_start;
  logic [1:0]  mode;
  logic [23:0] pix_in;
  logic        out_valid;
  logic [17:0] pix_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench position model
  logic [1:0]  m_frame;
  logic        m_line;
  logic        m_col;
  logic [17:0] last_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  depth_reducer u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
    .line_start(line_start), .mode(mode), .pix_in(pix_in),
    .out_valid(out_valid), .pix_out(pix_out)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_comp(input logic [1:0] md, input logic [7:0] c,
                                          input logic [1:0] f, input logic l, input logic k);
    logic [1:0] idx;
    logic [1:0] t;
    logic [5:0] top;
    idx = {l, k} ^ f;
    t = (idx == 2'd0) ? 2'd0 : (idx == 2'd1) ? 2'd2 : (idx == 2'd2) ? 2'd3 : 2'd1;
    top = c[7:2];
    if (md == 2'b01 && c[1:0] > t && top != 6'h3f) top = top + 6'd1;
    return top;
  endfunction

  function automatic logic [17:0] ref_px(input logic [1:0] md, input logic [23:0] p,
                                         input logic [1:0] f, input logic l, input logic k);
    if (md[1]) return p[17:0];
    return {ref_comp(md, p[23:16], f, l, k), ref_comp(md, p[15:8], f, l, k),
            ref_comp(md, p[7:0], f, l, k)};
  endfunction

  // drive one cycle, check registered result after the next edge
  task automatic send(input logic v, input logic fs, input logic ls,
                      input logic [23:0] px, input string req);
    logic [17:0] exp;
    @(negedge clk);
    in_valid = v; frame_start = fs; line_start = ls; pix_in = px;
    if (fs) begin m_frame = m_frame + 2'd1; m_line = 1'b0; m_col = 1'b0; end
    else if (ls) begin m_line = ~m_line; m_col = 1'b0; end
    exp = v ? ref_px(mode, px, m_frame, m_line, m_col) : last_out;
    if (v) m_col = ~m_col;
    @(posedge clk); #1;
    check({req, " R2 valid"}, {23'd0, out_valid}, {23'd0, v});
    check(v ? req : "R10 hold", {6'd0, pix_out}, {6'd0, exp});
    last_out = exp;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; frame_start = 1'b1; line_start = 1'b1;
    mode = 2'b01; pix_in = 24'hffffff;
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", {23'd0, out_valid}, 24'd0);
    check("R1 pixel in reset", {6'd0, pix_out}, 24'd0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0; frame_start = 1'b0; line_start = 1'b0;
    @(posedge clk); #1;
    check("R1 valid after reset", {23'd0, out_valid}, 24'd0);
    check("R1 pixel after reset", {6'd0, pix_out}, 24'd0);
    m_frame = 2'd0; m_line = 1'b0; m_col = 1'b0; last_out = 18'd0;
  endtask

  task automatic t_truncate();
    mode = 2'b00;
    send(1, 1, 1, 24'h123456, "R3 truncate");
    send(1, 0, 0, 24'hffffff, "R3 truncate");
    send(1, 0, 0, 24'h03fc81, "R3 truncate");
    send(1, 0, 1, 24'ha5c3e7, "R3 truncate");
  endtask

  task automatic t_pass();
    mode = 2'b10;
    send(1, 0, 0, 24'hfc0000, "R4 pass upper ignored");
    send(1, 0, 0, 24'h03ffff, "R4 pass");
    mode = 2'b11;
    send(1, 0, 0, 24'habcdef, "R4 pass alt code");
  endtask

  // R5 R7 R8 R9: eight frames, odd line counts, gaps inside lines
  task automatic t_dither_walk();
    mode = 2'b01;
    for (int f = 0; f < 8; f++) begin
      for (int ln = 0; ln < 3; ln++) begin
        for (int px = 0; px < 5; px++) begin
          if (px == 2) send(0, 0, 0, 24'h000000, "R9 gap");
          send(1, (ln == 0 && px == 0), (px == 0),
               24'h010203 + 24'h050607 * (f * 15 + ln * 5 + px) + 24'h030201 * px,
               "R5 R7 R8 R9 dither");
        end
      end
    end
  endtask

  task automatic t_saturate();
    mode = 2'b01;
    send(1, 1, 0, 24'hffffff, "R6 saturate");
    send(1, 0, 0, 24'hfefdff, "R6 saturate");
    send(1, 0, 1, 24'hffffff, "R6 saturate");
    send(1, 0, 0, 24'hfdfeff, "R6 saturate");
  endtask

  task automatic t_average();
    int sr, sg, sb;
    sr = 0; sg = 0; sb = 0;
    mode = 2'b01;
    for (int f = 0; f < 4; f++) begin
      send(1, 1, 1, 24'h864701, "R11 sample");
      sr += pix_out[17:12]; sg += pix_out[11:6]; sb += pix_out[5:0];
    end
    check("R11 red sum",   sr, 24'h86);
    check("R11 green sum", sg, 24'h47);
    check("R11 blue sum",  sb, 24'h01);
  endtask

  // R7: same position, frame k and k+4 match
  task automatic t_wrap();
    logic [17:0] first;
    mode = 2'b01;
    send(1, 1, 1, 24'h0d0e0f, "R7 wrap");
    first = pix_out;
    for (int f = 0; f < 3; f++) send(1, 1, 1, 24'h0d0e0f, "R7 wrap");
    send(1, 1, 1, 24'h0d0e0f, "R7 wrap");
    check("R7 repeat after four frames", {6'd0, pix_out}, {6'd0, first});
  endtask

  initial begin
    t_reset();
    t_truncate();
    t_pass();
    t_dither_walk();
    t_saturate();
    t_average();
    t_wrap();
    send(0, 0, 0, 24'h0, "R2 idle");
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule